// File: doc/BRIEF.md
# Two-Wire Serial Register Bank Slave

This block lets a host on a two-wire serial bus (I2C style) read and write a small bank of 8-bit control registers. The block samples the bus clock and data lines with the system clock. It recognises start, repeated-start and stop conditions and answers one fixed 7-bit device address. Every register is presented to the surrounding logic as one flat output vector. The block pulls the data line low only through an open-drain enable output, and it never holds the bus clock low.

A host stores a register index by sending a write-addressed transfer whose first byte after the address is that index. Any further bytes in the same transfer are written to consecutive registers. To read, the host sends a new start or a repeated start with the read direction, and the block returns data beginning at the stored index. The index moves forward by one after every byte in either direction and wraps at the top of the bank. The index is kept across stops, so successive reads continue where the last byte left off.

Top module: `twi_regbank_slave`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every register reads 0 on `regs_flat` and `sda_oe` is 0.
- R2: A start condition (data falling while the clock is high) puts the block back in the address phase from any state and discards a partly received byte. A stop condition (data rising while the clock is high) ends the transaction and releases the data line.
- R3: The address byte is sent MSB first. Bits 7:1 are compared with `DEV_ADDR`, and bit 0 gives the direction (1 = read, 0 = write). On a match the block pulls the data line low during the ninth clock. On a mismatch it never drives the line, and it ignores the bus until the next start or stop, leaving the registers unchanged.
- R4: In a write transfer, the first byte after the address loads the register index with that byte modulo `NUM_REGS`. This byte is acknowledged and changes no register.
- R5: Each later byte in a write transfer is stored into the register at the index, is acknowledged, and then advances the index by one.
- R6: The index wraps from `NUM_REGS`-1 to 0, in both directions of transfer.
- R7: In a read transfer the block puts the register at the index on the data line MSB first, valid while the clock is high, and advances the index by one after each byte.
- R8: If the host answers a read byte with an acknowledge (data low), the next register follows. If it answers with a no-acknowledge, the block releases the data line and does not drive it again until a start or stop.
- R9: The index persists across a stop and across a repeated start, so a read started either way begins at the index left by the last transfer.
- R10: The block begins to pull the data line low only while the synchronised clock is low.
- R11: Register i appears on `regs_flat[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_flat | output | NUM_REGS*8 | All registers, register i in byte lane i |

## Verification
Single-byte writes are swept over every base index. This shows that each index lands in its own byte lane and that the base byte sets the index without writing a register. Read bursts started by repeated start, from every base, show the MSB-first order, the post-byte increment and the wrap. They also show that a no-acknowledge from the host releases the line. A sweep over all 128 addresses separates a match from every near miss. Finally, short sequences cover the remaining cases: a start arriving mid-byte, an index byte above the bank size, a read reached after a stop, and a read that continues after a write.

// File: rtl/twi_regbank_pkg.sv
package twi_regbank_pkg;

    localparam int BYTE_BITS = 8;
    localparam int PTR_BITS  = 8;
    localparam int CNT_BITS  = 4;

    typedef logic [BYTE_BITS-1:0] byte_t;
    typedef logic [PTR_BITS-1:0]  ptr_t;
    typedef logic [CNT_BITS-1:0]  bitcnt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_PTR,
        ST_ACK_PTR,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_MACK,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        logic lvl;
        logic prev;
    } line_t;

    function automatic ptr_t ptr_step(ptr_t p, int unsigned n);
        return (32'(p) + 32'd1 >= n) ? '0 : ptr_t'(p + 1'b1);
    endfunction

    function automatic ptr_t ptr_base(byte_t b, int unsigned n);
        return ptr_t'({24'd0, b} % n);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_regbank_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw_i,
    output line_t            line_o [LINES]
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain  <= '1;
                last_q <= 1'b1;
            end else begin
                chain  <= {chain[STAGES-2:0], raw_i[g]};
                last_q <= chain[STAGES-1];
            end
        end

        assign line_o[g].lvl  = chain[STAGES-1];
        assign line_o[g].prev = last_q;
    end

endmodule

// File: rtl/twi_reg_array.sv
module twi_reg_array
    import twi_regbank_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  byte_t                     wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output byte_t                     rd_data,
    output logic [NUM_REGS*BYTE_BITS-1:0] regs_flat
);

    byte_t mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                mem[g] <= wr_data;
            end
        end
        assign regs_flat[g*BYTE_BITS +: BYTE_BITS] = mem[g];
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
    import twi_regbank_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3C,
    parameter int         NUM_REGS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  line_t  scl,
    input  line_t  sda,
    input  byte_t  rd_data,
    output logic   wr_en,
    output byte_t  wr_data,
    output ptr_t   ptr,
    output logic   sda_oe,
    output phase_e phase
);

    logic    scl_rise, scl_fall, start_c, stop_c, byte_full;
    bitcnt_t bit_cnt;
    byte_t   shreg, txreg;
    logic    rd_mode, mack_ok;

    always_comb begin
        scl_rise  = scl.lvl & ~scl.prev;
        scl_fall  = ~scl.lvl & scl.prev;
        start_c   = scl.lvl & scl.prev & sda.prev & ~sda.lvl;
        stop_c    = scl.lvl & scl.prev & ~sda.prev & sda.lvl;
        byte_full = (bit_cnt == bitcnt_t'(BYTE_BITS));
        wr_en     = (phase == ST_WDATA) && scl_fall && byte_full;
        wr_data   = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            rd_mode <= 1'b0;
            mack_ok <= 1'b0;
        end else if (start_c) begin
            phase   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_c) begin
            phase   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (phase)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && !byte_full) begin
                        shreg   <= {shreg[BYTE_BITS-2:0], sda.lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && byte_full) begin
                        if (phase == ST_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rd_mode <= shreg[0];
                                sda_oe  <= 1'b1;
                                phase   <= ST_ACK_ADDR;
                            end else begin
                                phase <= ST_SKIP;
                            end
                        end else if (phase == ST_PTR) begin
                            ptr    <= ptr_base(shreg, NUM_REGS);
                            sda_oe <= 1'b1;
                            phase  <= ST_ACK_PTR;
                        end else begin
                            ptr    <= ptr_step(ptr, NUM_REGS);
                            sda_oe <= 1'b1;
                            phase  <= ST_ACK_WDATA;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_BITS-1];
                            phase  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= ST_PTR;
                        end
                    end
                end
                ST_ACK_PTR, ST_ACK_WDATA: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        phase   <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (byte_full) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr_step(ptr, NUM_REGS);
                            phase  <= ST_MACK;
                        end else begin
                            txreg  <= {txreg[BYTE_BITS-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_BITS-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack_ok <= ~sda.lvl;
                    end else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mack_ok) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_BITS-1];
                            phase  <= ST_RDATA;
                        end else begin
                            phase <= ST_SKIP;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave
    import twi_regbank_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3C,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe,
    output logic [NUM_REGS*BYTE_BITS-1:0] regs_flat
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    line_t  lines [2];
    line_t  scl_ln, sda_ln;
    byte_t  rd_data, wr_data;
    logic   wr_en;
    ptr_t   ptr;
    phase_e phase;

    twi_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({sda_i, scl_i}),
        .line_o (lines)
    );

    assign scl_ln = lines[0];
    assign sda_ln = lines[1];

    twi_byte_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) eng_i (
        .clk     (clk),
        .rst     (rst),
        .scl     (scl_ln),
        .sda     (sda_ln),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ptr     (ptr),
        .sda_oe  (sda_oe),
        .phase   (phase)
    );

    twi_reg_array #(.NUM_REGS(NUM_REGS)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (ptr[IDX_W-1:0]),
        .wr_data   (wr_data),
        .rd_idx    (ptr[IDX_W-1:0]),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

endmodule

// File: rtl/twi_regbank_chk.sv
module twi_regbank_chk
    import twi_regbank_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic                          clk,
    input logic                          rst,
    input line_t                         scl_ln,
    input line_t                         sda_ln,
    input logic                          sda_oe,
    input logic                          wr_en,
    input ptr_t                          ptr,
    input phase_e                        phase,
    input logic [NUM_REGS*BYTE_BITS-1:0] regs_flat
);

    logic start_seen, stop_seen;
    assign start_seen = scl_ln.lvl && scl_ln.prev && sda_ln.prev && !sda_ln.lvl;
    assign stop_seen  = scl_ln.lvl && scl_ln.prev && !sda_ln.prev && sda_ln.lvl;

    assert_start_to_addr_R2: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> (phase == ST_ADDR && !sda_oe));

    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> (phase == ST_IDLE && !sda_oe));

    assert_quiet_when_unaddressed_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE || phase == ST_SKIP) |-> !sda_oe);

    assert_regs_only_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat));

    assert_ptr_in_bank_R6: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) < NUM_REGS);

    assert_drive_starts_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_ln.lvl);

endmodule

bind twi_regbank_slave twi_regbank_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .scl_ln    (scl_ln),
    .sda_ln    (sda_ln),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .ptr       (ptr),
    .phase     (phase),
    .regs_flat (regs_flat)
);

// File: tb/twi_regbank_slave_tb.sv
module twi_regbank_slave_tb_top;

    localparam int         PERIOD = 10;
    localparam int         Q      = 8;
    localparam int         NREG   = 16;
    localparam logic [6:0] DEV    = 7'h3C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs_flat;
    logic [NREG*8-1:0] exp_flat = '0;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    twi_regbank_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .regs_flat (regs_flat)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic wait_q();
        #(Q*PERIOD);
    endtask

    task automatic bus_start();
        if (scl_m == 1'b0) begin
            sda_m = 1'b1; wait_q();
            scl_m = 1'b1; wait_q();
        end
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q(); wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q(); wait_q();
            scl_m = 1'b0; wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        acked = (sda_line == 1'b0);
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl_m = 1'b1; wait_q();
            b[i] = sda_line;
            wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = ~give_ack; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0;
        sda_m = 1'b1; wait_q();
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) ^ (k >> 2));
    endfunction

    function automatic logic [7:0] exp_reg(input int idx);
        return exp_flat[(idx % NREG)*8 +: 8];
    endfunction

    task automatic write_burst(input logic [7:0] base, input int n, input int seed, input string req);
        bit ack;
        int idx;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R3 addr ack", {127'd0, ack}, 1);
        send_byte(base, ack);
        chk(ack, "R4 index ack", {127'd0, ack}, 1);
        idx = int'(base) % NREG;
        for (int k = 0; k < n; k++) begin
            send_byte(pat(seed + k), ack);
            chk(ack, "R5 data ack", {127'd0, ack}, 1);
            exp_flat[idx*8 +: 8] = pat(seed + k);
            idx = (idx + 1) % NREG;
        end
        bus_stop();
        chk(regs_flat == exp_flat, req, regs_flat, exp_flat);
    endtask

    logic [7:0] rb;
    bit         ack_g;

    initial begin
        #(PERIOD*200000/ 1 - PERIOD*20000);
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD*2);
        chk(regs_flat == '0, "R1 regs zero in reset", regs_flat, '0);
        chk(sda_oe == 1'b0, "R1 line released in reset", {127'd0, sda_oe}, '0);
        #(PERIOD*4);
        rst = 1'b0;
        #(PERIOD);
        chk(regs_flat == '0 && sda_oe == 1'b0, "R1 state after reset",
            {regs_flat[126:0], sda_oe}, '0);

        // R4 R5 R11: one byte at every base index lands in its own lane
        for (int b = 0; b < NREG; b++) begin
            write_burst(8'(b), 1, b, "R11 single write lane");
        end

        // R6: burst crossing the top of the bank
        write_burst(8'(NREG - 2), 4, 100, "R6 write wrap");

        // R4: index byte above bank size taken modulo NREG (0x25 -> 5)
        write_burst(8'h25, 1, 200, "R4 index modulo");

        // R7 R6 R8: read bursts via repeated start from every base
        for (int b = 0; b < NREG; b++) begin
            bus_start();
            send_byte({DEV, 1'b0}, ack_g);
            send_byte(8'(b), ack_g);
            bus_start();
            send_byte({DEV, 1'b1}, ack_g);
            chk(ack_g, "R3 read addr ack", {127'd0, ack_g}, 1);
            for (int k = 0; k < 3; k++) begin
                recv_byte(rb, k < 2);
                chk(rb == exp_reg(b + k), "R7 read data order/increment",
                    {120'd0, rb}, {120'd0, exp_reg(b + k)});
            end
            chk(sda_oe == 1'b0, "R8 released after nack", {127'd0, sda_oe}, '0);
            send_bits(8'h00, 2);
            chk(sda_oe == 1'b0, "R8 stays released", {127'd0, sda_oe}, '0);
            bus_stop();
        end

        // R3: address sweep, only DEV answers, nothing written
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack_g);
            chk(ack_g == (7'(a) == DEV), "R3 address match",
                {127'd0, ack_g}, {127'd0, (7'(a) == DEV)});
            bus_stop();
        end

        // R3: bytes after a mismatched address are ignored
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, ack_g);
        send_byte(8'h02, ack_g);
        chk(!ack_g, "R3 ignored index byte not acked", {127'd0, ack_g}, '0);
        send_byte(8'hEE, ack_g);
        chk(!ack_g, "R3 ignored data byte not acked", {127'd0, ack_g}, '0);
        bus_stop();
        chk(regs_flat == exp_flat, "R3 regs unchanged on mismatch", regs_flat, exp_flat);

        // R2: start in the middle of a data byte discards it
        bus_start();
        send_byte({DEV, 1'b0}, ack_g);
        send_byte(8'h02, ack_g);
        send_bits(8'h00, 4);
        bus_start();
        send_byte({DEV, 1'b0}, ack_g);
        send_byte(8'h09, ack_g);
        send_byte(8'h5A, ack_g);
        bus_stop();
        exp_flat[9*8 +: 8] = 8'h5A;
        chk(regs_flat == exp_flat, "R2 partial byte discarded", regs_flat, exp_flat);

        // R9: index survives a stop; read after a new start
        bus_start();
        send_byte({DEV, 1'b0}, ack_g);
        send_byte(8'h03, ack_g);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, ack_g);
        recv_byte(rb, 1'b1);
        chk(rb == exp_reg(3), "R9 read after stop", {120'd0, rb}, {120'd0, exp_reg(3)});
        recv_byte(rb, 1'b0);
        chk(rb == exp_reg(4), "R9 second byte", {120'd0, rb}, {120'd0, exp_reg(4)});
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, ack_g);
        recv_byte(rb, 1'b0);
        chk(rb == exp_reg(5), "R9 next read continues", {120'd0, rb}, {120'd0, exp_reg(5)});
        bus_stop();

        // R5 R9: read after a write continues at the incremented index
        bus_start();
        send_byte({DEV, 1'b0}, ack_g);
        send_byte(8'h07, ack_g);
        send_byte(8'hC3, ack_g);
        exp_flat[7*8 +: 8] = 8'hC3;
        bus_start();
        send_byte({DEV, 1'b1}, ack_g);
        recv_byte(rb, 1'b0);
        chk(rb == exp_reg(8), "R9 read after write", {120'd0, rb}, {120'd0, exp_reg(8)});
        bus_stop();
        chk(regs_flat == exp_flat, "R5 final bank", regs_flat, exp_flat);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule